// File: doc/BRIEF.md
# Delay-Loop Lock Sequencer

This block supervises the digital control side of a delay-locked loop in a synchronous memory front end. It does not model the delay line. It takes an active-low loop-disable input and the main input clock, and decides whether the loop is bypassed, restarting, acquiring lock or locked. It also tells the read pipeline which latency to use. In bypass the pipeline uses the legacy one-cycle latency. Otherwise it uses the loop-on latency.

A free-running reference clock runs all sequencing logic. The main clock toggles a single flop in its own domain. That toggle is synchronized into the reference domain and turned into one tick per main-clock cycle. Ticks drive the lock count and a separate output-impedance calibration timer. If the reference clock sees no tick for a set number of its periods (the equivalent of 30 ns), the main clock is taken as stopped and the loop restarts. A rising edge on the disable input also restarts the loop.

Top module: `dll_lock_seq`

## Requirements
- R1: While the synchronized `loop_on` is 0, the sequencer is in bypass. `bypass` is 1, `locked` is 0 and the lock count is cleared. The change takes effect SYNC_STAGES+1 reference cycles after `loop_on` falls.
- R2: When the synchronized `loop_on` changes from 0 to 1, the sequencer spends exactly one reference cycle in the restart state and then begins acquiring. This also applies after reset with `loop_on` already 1.
- R3: If no main-clock tick is seen for STOP_LIMIT consecutive reference cycles while acquiring or locked, the sequencer returns to restart. A shorter gap has no effect.
- R4: While acquiring, each main-clock tick advances the lock count. On the LOCK_CYCLES-th tick the sequencer enters the locked state.
- R5: `locked` is 1 only in the locked state. It rises on the reference cycle after the final tick is counted.
- R6: A restart event (clock stop or `loop_on` edge) during acquisition discards the partial count. Lock again needs a full LOCK_CYCLES ticks.
- R7: `lat_sel` is 0 (one-cycle legacy latency) in bypass and 1 (loop-on latency) in every other state.
- R8: `cal_done` rises after CAL_CYCLES main-clock ticks counted from reset, whatever the loop state. It then stays 1 until reset.
- R9: The state register is one-hot, with exactly one of bypass, restart, acquiring and locked set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main input clock whose activity is tracked |
| clk_ref | input | 1 | Free-running reference clock for all sequencing |
| rst_n | input | 1 | Synchronous active-low reset, seen in both domains |
| loop_on | input | 1 | Active-low loop disable; 0 bypasses the loop |
| locked | output | 1 | Loop is locked |
| bypass | output | 1 | Loop is bypassed |
| lat_sel | output | 1 | Read latency select: 0 legacy one-cycle, 1 loop-on |
| cal_done | output | 1 | Impedance calibration interval has elapsed |

## Verification
The bench builds the block with LOCK_CYCLES=20, CAL_CYCLES=12, STOP_LIMIT=6 and SYNC_STAGES=2, and runs the main clock at a quarter of the reference rate. These values make a full lock and the calibration interval short enough to repeat several times in one run. A clock stop in the middle of acquisition, a gap below the stop limit and a disable toggle while locked therefore all fall within a few hundred cycles. The normal four-cycle tick gap stays below the stop limit, so a running clock never raises a false restart.

// File: rtl/dll_seq_pkg.sv
// Shared types for the delay-loop lock sequencer.
package dll_seq_pkg;
    // One-hot sequencer state
    typedef enum logic [3:0] {
        ST_BYPASS  = 4'b0001,
        ST_RESTART = 4'b0010,
        ST_ACQUIRE = 4'b0100,
        ST_LOCKED  = 4'b1000
    } dll_state_e;
endpackage

// File: rtl/dll_sync_chain.sv
// Multi-flop synchronizer for a slow single-bit level.
// Assumes STAGES >= 2; output resets to 0.
module dll_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // shift the level through the chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dll_clk_monitor.sv
// Turns a synchronized main-clock toggle into one tick per main cycle
// and flags a clock stop after STOP_LIMIT reference cycles without a tick.
// Assumes the reference clock runs at more than twice the main clock.
module dll_clk_monitor #(
    parameter int STOP_LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_s,
    output logic tick,
    output logic stop_evt
);
    localparam int IW = $clog2(STOP_LIMIT + 1);

    logic          tog_d;
    logic [IW-1:0] idle;

    // delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) tog_d <= 1'b0;
        else        tog_d <= tog_s;
    end

    assign tick = tog_s ^ tog_d;

    // saturating count of reference cycles since the last tick
    always_ff @(posedge clk) begin
        if (!rst_n)                          idle <= '0;
        else if (tick)                       idle <= '0;
        else if (idle != IW'(STOP_LIMIT))    idle <= idle + 1'b1;
    end

    assign stop_evt = !tick && (idle == IW'(STOP_LIMIT - 1));
endmodule

// File: rtl/dll_seq_fsm.sv
// Bypass / restart / acquire / locked sequencer with lock counter.
// Assumes LOCK_CYCLES >= 2; tick and stop_evt are never high together.
module dll_seq_fsm
    import dll_seq_pkg::*;
#(
    parameter int LOCK_CYCLES = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_s,
    input  logic       tick,
    input  logic       stop_evt,
    output dll_state_e state
);
    localparam int LW = $clog2(LOCK_CYCLES);

    dll_state_e    nxt;
    logic [LW-1:0] lcnt;
    logic          lcnt_last;

    assign lcnt_last = (lcnt == LW'(LOCK_CYCLES - 1));

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_BYPASS:  if (en_s) nxt = ST_RESTART;
            ST_RESTART: nxt = en_s ? ST_ACQUIRE : ST_BYPASS;
            ST_ACQUIRE: begin
                if (!en_s)                 nxt = ST_BYPASS;
                else if (stop_evt)         nxt = ST_RESTART;
                else if (tick && lcnt_last) nxt = ST_LOCKED;
            end
            ST_LOCKED: begin
                if (!en_s)         nxt = ST_BYPASS;
                else if (stop_evt) nxt = ST_RESTART;
            end
            default: nxt = ST_BYPASS;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_BYPASS;
        else        state <= nxt;
    end

    // lock counter: runs only while acquiring
    always_ff @(posedge clk) begin
        if (!rst_n)                      lcnt <= '0;
        else if (state != ST_ACQUIRE)    lcnt <= '0;
        else if (tick && !lcnt_last)     lcnt <= lcnt + 1'b1;
    end
endmodule

// File: rtl/dll_cal_timer.sv
// Counts main-clock ticks after reset and raises a sticky done flag
// at CAL_CYCLES. Assumes CAL_CYCLES >= 2.
module dll_cal_timer #(
    parameter int CAL_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(CAL_CYCLES);

    logic [CW-1:0] cnt;

    // count ticks until the interval completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (tick && !done) begin
            if (cnt == CW'(CAL_CYCLES - 1)) done <= 1'b1;
            else                            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dll_lock_seq.sv
// Top of the delay-loop lock sequencer. A toggle flop in the main domain
// reports main-clock activity into the reference domain, where all
// sequencing runs. Assumes rst_n is held while both clocks run.
module dll_lock_seq
    import dll_seq_pkg::*;
#(
    parameter int LOCK_CYCLES = 2048,
    parameter int CAL_CYCLES  = 1024,
    parameter int STOP_LIMIT  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_main,
    input  logic clk_ref,
    input  logic rst_n,
    input  logic loop_on,
    output logic locked,
    output logic bypass,
    output logic lat_sel,
    output logic cal_done
);
    logic       main_tog;
    logic       tog_s;
    logic       en_s;
    logic       tick;
    logic       stop_evt;
    dll_state_e state;

    // activity toggle in the main-clock domain
    always_ff @(posedge clk_main) begin
        if (!rst_n) main_tog <= 1'b0;
        else        main_tog <= ~main_tog;
    end

    dll_sync_chain #(.STAGES(SYNC_STAGES)) u_sync_tog (
        .clk(clk_ref), .rst_n(rst_n), .d(main_tog), .q(tog_s)
    );

    dll_sync_chain #(.STAGES(SYNC_STAGES)) u_sync_en (
        .clk(clk_ref), .rst_n(rst_n), .d(loop_on), .q(en_s)
    );

    dll_clk_monitor #(.STOP_LIMIT(STOP_LIMIT)) u_mon (
        .clk(clk_ref), .rst_n(rst_n), .tog_s(tog_s),
        .tick(tick), .stop_evt(stop_evt)
    );

    dll_seq_fsm #(.LOCK_CYCLES(LOCK_CYCLES)) u_fsm (
        .clk(clk_ref), .rst_n(rst_n), .en_s(en_s), .tick(tick),
        .stop_evt(stop_evt), .state(state)
    );

    dll_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
        .clk(clk_ref), .rst_n(rst_n), .tick(tick), .done(cal_done)
    );

    assign locked  = state[3];
    assign bypass  = state[0];
    assign lat_sel = ~state[0];
endmodule

// File: rtl/dll_lock_seq_chk.sv
// Checker for the delay-loop lock sequencer, bound to the top module.
module dll_lock_seq_chk (
    input logic       clk_ref,
    input logic       rst_n,
    input logic [3:0] state,
    input logic       en_s,
    input logic       tick,
    input logic       locked,
    input logic       bypass,
    input logic       lat_sel,
    input logic       cal_done
);
    AST_STATE_ONE_HOT: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $countones(state) == 1); // R9
    AST_DISABLE_BYPASS: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !en_s |=> bypass && !locked); // R1
    AST_ENABLE_RESTART: assert property (@(posedge clk_ref) disable iff (!rst_n)
        bypass && en_s |=> state == 4'b0010); // R2
    AST_LOCK_FROM_ACQUIRE: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(locked) |-> $past(state) == 4'b0100 && $past(tick)); // R4
    AST_LOCKED_NOT_BYPASS: assert property (@(posedge clk_ref) disable iff (!rst_n)
        locked |-> !bypass && lat_sel); // R5
    AST_LAT_LEGACY: assert property (@(posedge clk_ref) disable iff (!rst_n)
        bypass |-> !lat_sel); // R7
    AST_CAL_STICKY: assert property (@(posedge clk_ref) disable iff (!rst_n)
        cal_done |=> cal_done); // R8
endmodule

bind dll_lock_seq dll_lock_seq_chk u_chk (
    .clk_ref(clk_ref), .rst_n(rst_n), .state(state), .en_s(en_s),
    .tick(tick), .locked(locked), .bypass(bypass), .lat_sel(lat_sel),
    .cal_done(cal_done)
);

// File: tb/dll_lock_seq_test.sv
// Bench: behavioural cycle model of the sequencer compared every cycle,
// plus directed checks at the interesting points.
module dll_lock_seq_test;
    localparam int LOCK = 20;
    localparam int CAL  = 12;
    localparam int STOP = 6;

    logic clk_ref = 1'b0;
    logic clk_main = 1'b0;
    logic rst_n = 1'b0;
    logic loop_on = 1'b0;
    logic locked, bypass, lat_sel, cal_done;

    int total = 0;
    int bad = 0;
    bit armed = 0;
    bit main_run = 1;
    int phase = 3;
    bit m_tg = 0;

    dll_lock_seq #(.LOCK_CYCLES(LOCK), .CAL_CYCLES(CAL), .STOP_LIMIT(STOP),
                   .SYNC_STAGES(2)) uut (
        .clk_main(clk_main), .clk_ref(clk_ref), .rst_n(rst_n), .loop_on(loop_on),
        .locked(locked), .bypass(bypass), .lat_sel(lat_sel), .cal_done(cal_done)
    );

    always #2 clk_ref = ~clk_ref;   // 250 MHz reference

    // main clock: one quarter of the reference rate, edges on ref falling edges
    always @(negedge clk_ref) begin
        if (main_run) begin
            phase = (phase + 1) % 4;
            clk_main = (phase < 2);
            if (phase == 0) m_tg = rst_n ? ~m_tg : 1'b0;
        end
    end

    // reference model: 0 bypass, 1 restart, 2 acquire, 3 locked
    int  m_st = 0;
    int  m_lcnt = 0;
    int  m_idle = 0;
    int  m_ccnt = 0;
    bit  m_cal = 0;
    bit  h_tg[$];
    bit  h_en[$];

    always @(posedge clk_ref) begin
        if (!rst_n) begin
            armed = 1;
            m_st = 0; m_lcnt = 0; m_idle = 0; m_ccnt = 0; m_cal = 0;
            h_tg = '{0, 0, 0};
            h_en = '{0, 0, 0};
        end else begin
            bit tk, en, stp;
            int n;
            n  = h_tg.size();
            tk = h_tg[n-2] ^ h_tg[n-3];
            en = h_en[h_en.size()-2];
            stp = !tk && (m_idle == STOP - 1);
            if (tk) m_idle = 0; else if (m_idle < STOP) m_idle++;
            if (tk && !m_cal) begin
                m_ccnt++;
                if (m_ccnt == CAL) m_cal = 1;
            end
            case (m_st)
                0: if (en) m_st = 1;
                1: begin m_st = en ? 2 : 0; m_lcnt = 0; end
                2: begin
                    if (!en) m_st = 0;
                    else if (stp) m_st = 1;
                    else if (tk) begin
                        m_lcnt++;
                        if (m_lcnt == LOCK) m_st = 3;
                    end
                end
                default: begin
                    if (!en) m_st = 0;
                    else if (stp) m_st = 1;
                end
            endcase
            if (m_st != 2) m_lcnt = 0;
            h_tg.push_back(m_tg);
            h_en.push_back(loop_on);
            if (h_tg.size() > 4) void'(h_tg.pop_front());
            if (h_en.size() > 4) void'(h_en.pop_front());
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk_ref) begin
        if (armed) begin
            chk("R5 locked", locked, m_st == 3);
            chk("R1 bypass", bypass, m_st == 0);
            chk("R7 lat_sel", lat_sel, m_st != 0);
            chk("R8 cal_done", cal_done, m_cal);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk_ref);
        #1;
    endtask

    // watchdog
    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(6);
        rst_n = 1'b1;
        // R1 R7 R8: reset state
        chk("R1 reset bypass", bypass, 1'b1);
        chk("R7 reset latency", lat_sel, 1'b0);
        chk("R8 reset cal", cal_done, 1'b0);
        cyc(10);
        chk("R1 still bypass", bypass, 1'b1);
        // R2 R4: enable and lock
        loop_on = 1'b1;
        cyc(4);
        chk("R2 left bypass", bypass, 1'b0);
        chk("R4 not yet locked", locked, 1'b0);
        cyc(LOCK * 4 + 10);
        chk("R4 locked after count", locked, 1'b1);
        chk("R8 cal done", cal_done, 1'b1);
        // R3: short gap ignored
        main_run = 0; cyc(1); main_run = 1;
        cyc(8);
        chk("R3 short gap ignored", locked, 1'b1);
        // R3: long stop restarts
        main_run = 0; cyc(12);
        chk("R3 stop drops lock", locked, 1'b0);
        main_run = 1;
        // R6: partial count then stop again
        cyc(LOCK * 2);
        chk("R6 partial not locked", locked, 1'b0);
        main_run = 0; cyc(12); main_run = 1;
        cyc(LOCK * 4 - 16);
        chk("R6 count restarted", locked, 1'b0);
        cyc(40);
        chk("R6 relock", locked, 1'b1);
        // R1 R7: disable while locked
        loop_on = 1'b0;
        cyc(4);
        chk("R1 disable bypass", bypass, 1'b1);
        chk("R7 legacy latency", lat_sel, 1'b0);
        loop_on = 1'b1;
        cyc(LOCK * 4 + 12);
        chk("R2 relock after enable", locked, 1'b1);
        chk("R8 cal sticky", cal_done, 1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule